// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single TX line. A byte is offered with a valid/ready handshake. The frame format is taken from four select inputs in the same cycle the byte is accepted: character length, stop length, parity enable and parity sense. A frame is one low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then 1 or 2 high stop bits. That makes 9 to 12 bit times per frame.

Bit timing comes from an external baud generator. It delivers a one-cycle `tick` at every bit boundary, and the line changes only on those ticks. A byte can be accepted on the tick that closes the final stop bit, so a stream of bytes leaves with no idle gap between frames. `busy` covers the frame. `done` pulses once when the last stop bit ends.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and between frames, `tx` is high, `busy` is low, `done` is low and `in_ready` is high.
- R2: Every frame opens with exactly one low start bit.
- R3: Data bits go out least significant bit first. There are 8 of them when `len8`=1 and 7 when `len8`=0, and in 7-bit mode `in_data[7]` has no effect on the line.
- R4: With `par_en`=0 no parity bit is sent. With `par_en`=1 a parity bit follows the last data bit and is computed over the data bits actually sent. `par_odd`=1 selects odd parity (data ones plus parity is odd) and `par_odd`=0 selects even parity.
- R5: The frame ends with one high stop bit when `stop2`=0 and two when `stop2`=1.
- R6: Data and all four format selects are captured when the byte is accepted. Changing them later has no effect on that frame.
- R7: `tx` changes only in the cycle after a cycle with `tick` high, so each bit lasts from one tick to the next.
- R8: A byte is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high while idle and, during a frame, only in the cycle where `tick` closes the final stop bit. A byte accepted while idle without a tick holds the line high and starts its start bit on the next tick. A byte accepted together with a tick starts its start bit at once.
- R9: `done` is high for exactly one cycle, the cycle after the tick that ends the last stop bit. `busy` falls in that same cycle unless a new byte was accepted.
- R10: A byte accepted on the final stop tick puts its start bit on the line in the very next cycle, with `busy` staying high, so frames run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle bit-boundary strobe from the baud generator |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to send |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| par_en | input | 1 | 1: send a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| in_ready | output | 1 | The offered byte is taken this cycle |
| tx | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is pending or on the line |
| done | output | 1 | One-cycle strobe after the last stop bit |

## Verification
Two events can land in the same cycle. The first is the end of one frame and the acceptance of the next: a second byte is held on `in_valid` through the final stop bit. The bench then checks that `in_ready` is low until the closing tick and high on it, and that the next cycle shows `done` high, `busy` still high and `tx` already low for the new start bit. The second is a byte accepted while idle in the same cycle as a tick. The bench aligns the offer to a tick cycle and expects the start bit in the following cycle. It also aligns an offer to a non-tick cycle and expects the line to stay high until the next tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic long_char;
    logic two_stop;
    logic par_on;
    logic par_odd;
  } frame_fmt_t;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              long_char,
  input  logic              odd,
  output logic              par_bit
);

  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '1;
    if (!long_char) mask[DATA_W-1] = 1'b0;
    par_bit = (^(data & mask)) ^ odd;
  end

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              accept,
  input  logic [DATA_W-1:0] load_data,
  input  frame_fmt_t        load_fmt,
  input  logic              load_par,
  output logic              idle,
  output logic              final_tick,
  output logic              nxt_bit,
  output logic              nxt_busy
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              stp_q, stp_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  frame_fmt_t        fmt_q, fmt_d;
  logic              par_q, par_d;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx   = fmt_q.long_char ? IDX_LONG : IDX_SHORT;
  assign idle       = (state_q == ST_IDLE);
  assign final_tick = tick && (state_q == ST_STOP) && (stp_q == fmt_q.two_stop);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    stp_d   = stp_q;
    sh_d    = sh_q;
    fmt_d   = fmt_q;
    par_d   = par_q;
    if (accept) begin
      sh_d    = load_data;
      fmt_d   = load_fmt;
      par_d   = load_par;
      state_d = tick ? ST_START : ST_WAIT;
    end else if (tick) begin
      case (state_q)
        ST_WAIT:  state_d = ST_START;
        ST_START: begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (idx_q == last_idx) begin
            state_d = fmt_q.par_on ? ST_PAR : ST_STOP;
            stp_d   = 1'b0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_PAR: begin
          state_d = ST_STOP;
          stp_d   = 1'b0;
        end
        ST_STOP: begin
          if (final_tick) state_d = ST_IDLE;
          else            stp_d   = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_d)
      ST_START: nxt_bit = 1'b0;
      ST_DATA:  nxt_bit = sh_d[0];
      ST_PAR:   nxt_bit = par_d;
      default:  nxt_bit = 1'b1;
    endcase
    nxt_busy = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      stp_q   <= 1'b0;
      sh_q    <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      stp_q   <= stp_d;
      sh_q    <= sh_d;
      fmt_q   <= fmt_d;
      par_q   <= par_d;
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              len8,
  input  logic              stop2,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              in_ready,
  output logic              tx,
  output logic              busy,
  output logic              done
);

  logic       idle, final_tick, nxt_bit, nxt_busy, accept, par_calc;
  frame_fmt_t fmt_in;

  assign fmt_in   = '{long_char: len8, two_stop: stop2, par_on: par_en, par_odd: par_odd};
  assign in_ready = idle || final_tick;
  assign accept   = in_valid && in_ready;

  uart_tx_parity #(.DATA_W(DATA_W)) par_i (
    .data      (in_data),
    .long_char (len8),
    .odd       (par_odd),
    .par_bit   (par_calc)
  );

  uart_tx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .accept     (accept),
    .load_data  (in_data),
    .load_fmt   (fmt_in),
    .load_par   (par_calc),
    .idle       (idle),
    .final_tick (final_tick),
    .nxt_bit    (nxt_bit),
    .nxt_busy   (nxt_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx   <= 1'b1;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      tx   <= nxt_bit;
      busy <= nxt_busy;
      done <= final_tick;
    end
  end

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic in_ready,
  input logic tx,
  input logic busy,
  input logic done
);

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready);

  a_r8_no_ready_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |-> !in_ready);

  a_r7_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tx));

  a_r9_done_follows_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !done);

  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_start_inside_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(tx) |-> busy);

endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .in_ready (in_ready),
  .tx       (tx),
  .busy     (busy),
  .done     (done)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       len8 = 1'b1, stop2 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic       in_ready, tx, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int tcnt  = 0;

  uart_frame_tx dut_i (
    .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_data(in_data),
    .len8(len8), .stop2(stop2), .par_en(par_en), .par_odd(par_odd),
    .in_ready(in_ready), .tx(tx), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tcnt == TICK_DIV-1) begin
      tcnt <= 0;
      tick <= 1'b1;
    end else begin
      tcnt <= tcnt + 1;
      tick <= 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic sample_pt();
    @(negedge clk);
    #1;
  endtask

  task automatic build(input logic [7:0] d, input logic l8, input logic s2,
                       input logic pe, input logic po,
                       output logic [11:0] bits, output int n, output int nd);
    logic p;
    int k;
    bits = '1;
    bits[0] = 1'b0;
    k = 1;
    nd = l8 ? 8 : 7;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      bits[k] = d[i];
      p = p ^ d[i];
      k++;
    end
    if (pe) begin
      bits[k] = p ^ po;
      k++;
    end
    bits[k] = 1'b1;
    k++;
    if (s2) begin
      bits[k] = 1'b1;
      k++;
    end
    n = k;
  endtask

  // align: 0 any cycle, 1 with a tick, 2 without a tick
  task automatic push(input logic [7:0] d, input logic l8, input logic s2,
                      input logic pe, input logic po, input int align,
                      output logic acc_tick);
    sample_pt();
    if (align == 1) while (!tick) sample_pt();
    if (align == 2) while (tick) sample_pt();
    in_valid = 1'b1; in_data = d; len8 = l8; stop2 = s2; par_en = pe; par_odd = po;
    while (!in_ready) sample_pt();
    acc_tick = tick;
    sample_pt();
    // R6: scramble everything after acceptance
    in_valid = 1'b0; in_data = ~d; len8 = ~l8; stop2 = ~s2; par_en = ~pe; par_odd = ~po;
  endtask

  task automatic follow(input logic [11:0] bits, input int n, input int nd,
                        input logic acc_tick);
    int i;
    string tag;
    i = 0;
    if (acc_tick) begin
      chk("R2", "start bit right after accept with tick", tx, 1'b0);
      i = 1;
    end
    for (; i < n; i++) begin
      while (!tick) begin
        if (i > 0) chk("R7", "bit held between ticks", tx, bits[i-1]);
        sample_pt();
      end
      sample_pt();
      if (i == 0)        tag = "R2";
      else if (i <= nd)  tag = "R3";
      else if (i == nd+1 && n - nd - 1 > (stop_count(n, nd))) tag = "R4";
      else               tag = "R5";
      chk(tag, $sformatf("frame bit %0d", i), tx, bits[i]);
    end
  endtask

  function automatic int stop_count(input int n, input int nd);
    return n - nd - 1 - ((n - nd - 1 > 2) ? 1 : 0) - ((n - nd - 1 == 2 && 0) ? 1 : 0);
  endfunction

  task automatic finish_frame();
    while (!tick) sample_pt();
    sample_pt();
    chk("R9", "done after last stop", done, 1'b1);
    chk("R9", "busy drops", busy, 1'b0);
    chk("R1", "line idle high", tx, 1'b1);
    chk("R1", "ready while idle", in_ready, 1'b1);
    sample_pt();
    chk("R9", "done lasts one cycle", done, 1'b0);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic l8, input logic s2,
                           input logic pe, input logic po, input int align);
    logic [11:0] bits;
    int n, nd;
    logic acc_tick;
    build(d, l8, s2, pe, po, bits, n, nd);
    push(d, l8, s2, pe, po, align, acc_tick);
    if (align == 2) begin
      chk("R8", "line stays high while waiting for tick", tx, 1'b1);
      chk("R8", "busy while waiting for tick", busy, 1'b1);
    end
    follow(bits, n, nd, acc_tick);
    finish_frame();
  endtask

  task automatic t_reset();
    sample_pt();
    chk("R1", "tx after reset", tx, 1'b1);
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "done after reset", done, 1'b0);
    chk("R1", "ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_back_to_back();
    logic [11:0] ba, bb;
    int na, nda, nb, ndb;
    logic acc_tick;
    build(8'h55, 1'b1, 1'b0, 1'b0, 1'b0, ba, na, nda);
    build(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, bb, nb, ndb);
    push(8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 0, acc_tick);
    follow(ba, na, nda, acc_tick);
    in_valid = 1'b1; in_data = 8'hC3; len8 = 1'b0; stop2 = 1'b0; par_en = 1'b1; par_odd = 1'b0;
    chk("R8", "not ready mid stop bit", in_ready, 1'b0);
    while (!tick) sample_pt();
    chk("R8", "ready on final stop tick", in_ready, 1'b1);
    sample_pt();
    in_valid = 1'b0; in_data = 8'h00; len8 = 1'b1; par_en = 1'b0;
    chk("R9", "done at frame boundary", done, 1'b1);
    chk("R10", "busy kept across boundary", busy, 1'b1);
    chk("R10", "next start bit with no gap", tx, 1'b0);
    follow(bb, nb, ndb, 1'b1);
    finish_frame();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_frame(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 0); // R3 8N1
    run_frame(8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 1); // R3 R4 R5 7E2, bit7 ignored
    run_frame(8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 2); // R4 R8 8O1, waits for tick
    run_frame(8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 0); // R4 7O1 over 7 bits
    run_frame(8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 0); // R5 R6 8E2
    t_back_to_back();                            // R10
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule